// File: doc/BRIEF.md
# Address Translation Window Unit

This block holds two banks of programmable address windows, one for the inbound direction and one for the outbound direction. Software does not see every window at once. It first writes a selector register that names a bank and a window number. A shared group of register offsets then reaches the base, limit, target and two control words of that one window.

On the lookup side, the block takes a request address and a direction. It reports whether the address lands in an enabled window of that bank. A window of memory type returns the translated address. A window of configuration type returns the bus number, the device/function and the register offset inside configuration space. Changes written to a window stay dormant until software writes its second control word. That write captures the window's whole setup at once, so a live mapping is never seen half-edited.

Top module: `xlat_window_unit`

## Requirements
- R1: The selector register at offset 0x900 keeps bit 31 as the bank choice (1 = inbound, 0 = outbound) and bits 3:0 as the window number. Reading it returns those bits, and every other bit reads 0. Reset value is 0.
- R2: For the selected window, the following offsets read back the last value written: 0x904 type word, 0x908 control word (bit 31 = enable), 0x90C base bits 31:0, 0x910 base bits 63:32, 0x914 limit (32 bits), 0x918 target bits 31:0 and 0x91C target bits 63:32. Any other offset reads 0, and writes to it change nothing.
- R3: When the selected window number is NUM_REGIONS or higher, writes to window offsets are ignored and reads of them return 0.
- R4: At reset every window has base 0, target 0, limit 0xFFFFFFFF and type word 0. Inbound window 0 alone has its control word at 0x80000000 and is enabled. Every other window is disabled.
- R5: Type, enable, base, limit and target used for lookups are captured only when the window's control word (0x908) is written. Writes to the other offsets leave lookups unchanged until then.
- R6: A window matches when it is enabled, belongs to the bank chosen by lk_inbound, and base <= address <= limit, with the limit zero-extended to 64 bits.
- R7: On a memory-type hit (captured type word 0), lk_addr_out = target + (address - base), modulo 2^64.
- R8: On a configuration-type hit (captured type word not 0), lk_cfg is 1, lk_bus = target[31:24], lk_devfn = target[23:16], lk_cfg_off = the low CFG_W bits of (address - base), and lk_addr_out = address.
- R9: When several windows match, the lowest-numbered one is used, and lk_region reports its number.
- R10: On a miss, lk_hit and lk_cfg are 0, lk_bus, lk_devfn and lk_cfg_off are 0, and lk_addr_out equals the request address.
- R11: A window whose type is changed and then captured answers only in its new type. A type change that has not been captured leaves the old type in force.
- R12: The two banks are independent. Writing a window in one bank changes neither the registers nor the lookups of the other bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| lk_inbound | input | 1 | Lookup bank: 1 inbound, 0 outbound |
| lk_addr | input | 64 | Request address |
| lk_hit | output | 1 | An enabled window matched |
| lk_cfg | output | 1 | The match is of configuration type |
| lk_region | output | IDX_W | Number of the matching window |
| lk_addr_out | output | 64 | Translated or passed-through address |
| lk_bus | output | 8 | Bus number for configuration hits |
| lk_devfn | output | 8 | Device/function for configuration hits |
| lk_cfg_off | output | CFG_W | Configuration space offset |

## Verification
The bench builds the block with NUM_REGIONS = 4 and CFG_W = 12. With four windows per bank, every window of both banks can be read back field by field after reset. It also puts out-of-range window numbers (4 to 15) within reach of the 4-bit selector, so the ignored-write path is exercised. Overlapping windows at indices 1 and 2 exercise the priority order. Address sweeps run across window edges, and each result is compared with a bench-side model of the captured and live register state. The 12-bit configuration offset makes the masking visible for a window larger than 4 KiB.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   localparam int REG_AW  = 12;
   localparam int LK_AW   = 64;

   localparam logic [REG_AW-1:0] OFF_VIEW   = 12'h900;
   localparam logic [REG_AW-1:0] OFF_TYPE   = 12'h904;
   localparam logic [REG_AW-1:0] OFF_CTRL   = 12'h908;
   localparam logic [REG_AW-1:0] OFF_BASE_L = 12'h90C;
   localparam logic [REG_AW-1:0] OFF_BASE_H = 12'h910;
   localparam logic [REG_AW-1:0] OFF_LIMIT  = 12'h914;
   localparam logic [REG_AW-1:0] OFF_TGT_L  = 12'h918;
   localparam logic [REG_AW-1:0] OFF_TGT_H  = 12'h91C;

   typedef enum logic [2:0] {
      FLD_TYPE, FLD_CTRL, FLD_BASE_L, FLD_BASE_H,
      FLD_LIMIT, FLD_TGT_L, FLD_TGT_H, FLD_NONE
   } fld_e;

   typedef struct packed {
      logic [31:0]       typ;
      logic [31:0]       ctrl;
      logic [LK_AW-1:0]  base;
      logic [31:0]       limit;
      logic [LK_AW-1:0]  target;
   } win_regs_t;

   function automatic fld_e decode_fld(input logic [REG_AW-1:0] off);
      case (off)
         OFF_TYPE:   return FLD_TYPE;
         OFF_CTRL:   return FLD_CTRL;
         OFF_BASE_L: return FLD_BASE_L;
         OFF_BASE_H: return FLD_BASE_H;
         OFF_LIMIT:  return FLD_LIMIT;
         OFF_TGT_L:  return FLD_TGT_L;
         OFF_TGT_H:  return FLD_TGT_H;
         default:    return FLD_NONE;
      endcase
   endfunction

endpackage

// File: rtl/xlat_region.sv
module xlat_region
   import xlat_pkg::*;
#(
   parameter int CFG_W   = 12,
   parameter bit INIT_EN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  fld_e              fld,
   input  logic [31:0]       wdata,
   input  logic [LK_AW-1:0]  lk_addr,
   output win_regs_t         live,
   output logic              hit,
   output logic              is_cfg,
   output logic [LK_AW-1:0]  xaddr,
   output logic [7:0]        bus,
   output logic [7:0]        devfn,
   output logic [CFG_W-1:0]  cfg_off
);

   localparam logic [31:0] CTRL_RST = INIT_EN ? 32'h8000_0000 : 32'h0;

   logic             c_en, c_cfg;
   logic [LK_AW-1:0] c_base, c_tgt;
   logic [31:0]      c_lim;
   logic [LK_AW-1:0] ofs;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live   <= '{typ: 32'h0, ctrl: CTRL_RST, base: '0,
                     limit: 32'hFFFF_FFFF, target: '0};
         c_en   <= INIT_EN;
         c_cfg  <= 1'b0;
         c_base <= '0;
         c_lim  <= 32'hFFFF_FFFF;
         c_tgt  <= '0;
      end else if (wr_en) begin
         case (fld)
            FLD_TYPE:   live.typ            <= wdata;
            FLD_BASE_L: live.base[31:0]     <= wdata;
            FLD_BASE_H: live.base[63:32]    <= wdata;
            FLD_LIMIT:  live.limit          <= wdata;
            FLD_TGT_L:  live.target[31:0]   <= wdata;
            FLD_TGT_H:  live.target[63:32]  <= wdata;
            FLD_CTRL: begin
               live.ctrl <= wdata;
               c_en      <= wdata[31];
               c_cfg     <= (live.typ != 32'h0);
               c_base    <= live.base;
               c_lim     <= live.limit;
               c_tgt     <= live.target;
            end
            default: ;
         endcase
      end
   end

   assign ofs     = lk_addr - c_base;
   assign hit     = c_en && (lk_addr >= c_base) && (lk_addr <= {32'h0, c_lim});
   assign is_cfg  = c_cfg;
   assign xaddr   = c_tgt + ofs;
   assign bus     = c_tgt[31:24];
   assign devfn   = c_tgt[23:16];
   assign cfg_off = ofs[CFG_W-1:0];

endmodule

// File: rtl/xlat_pick.sv
module xlat_pick #(
   parameter int N     = 16,
   parameter int IDX_W = 4
) (
   input  logic [N-1:0]     req,
   output logic             found,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            found = 1'b1;
            idx   = IDX_W'(i);
         end
      end
   end

endmodule

// File: rtl/xlat_window_unit.sv
module xlat_window_unit
   import xlat_pkg::*;
#(
   parameter  int NUM_REGIONS = 16,
   parameter  int CFG_W       = 12,
   localparam int IDX_W       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               reg_we,
   input  logic [11:0]        reg_addr,
   input  logic [31:0]        reg_wdata,
   output logic [31:0]        reg_rdata,
   input  logic               lk_inbound,
   input  logic [63:0]        lk_addr,
   output logic               lk_hit,
   output logic               lk_cfg,
   output logic [IDX_W-1:0]   lk_region,
   output logic [63:0]        lk_addr_out,
   output logic [7:0]         lk_bus,
   output logic [7:0]         lk_devfn,
   output logic [CFG_W-1:0]   lk_cfg_off
);

   generate
      if (NUM_REGIONS < 1 || NUM_REGIONS > 16) begin : g_bad_n
         $error("NUM_REGIONS must lie in 1..16");
      end
      if (CFG_W < 8 || CFG_W > 32) begin : g_bad_cfg
         $error("CFG_W must lie in 8..32");
      end
   endgenerate

   logic              vp_in;
   logic [3:0]        vp_idx;
   logic              sel_ok;
   logic [IDX_W-1:0]  sel_r;
   fld_e              fld;

   win_regs_t         live    [2][NUM_REGIONS];
   logic [NUM_REGIONS-1:0] hv [2];
   logic              cfgv    [2][NUM_REGIONS];
   logic [63:0]       xav     [2][NUM_REGIONS];
   logic [7:0]        busv    [2][NUM_REGIONS];
   logic [7:0]        dfv     [2][NUM_REGIONS];
   logic [CFG_W-1:0]  offv    [2][NUM_REGIONS];

   assign fld    = decode_fld(reg_addr);
   assign sel_ok = ({28'h0, vp_idx} < NUM_REGIONS);
   assign sel_r  = vp_idx[IDX_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vp_in  <= 1'b0;
         vp_idx <= 4'h0;
      end else if (reg_we && reg_addr == OFF_VIEW) begin
         vp_in  <= reg_wdata[31];
         vp_idx <= reg_wdata[3:0];
      end
   end

   for (genvar b = 0; b < 2; b++) begin : g_bank
      for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_win
         logic wr_this;
         assign wr_this = reg_we && (fld != FLD_NONE) && sel_ok &&
                          (vp_in == b[0]) && ({28'h0, vp_idx} == r);
         xlat_region #(
            .CFG_W   (CFG_W),
            .INIT_EN ((b == 1) && (r == 0))
         ) u_win (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_this),
            .fld     (fld),
            .wdata   (reg_wdata),
            .lk_addr (lk_addr),
            .live    (live[b][r]),
            .hit     (hv[b][r]),
            .is_cfg  (cfgv[b][r]),
            .xaddr   (xav[b][r]),
            .bus     (busv[b][r]),
            .devfn   (dfv[b][r]),
            .cfg_off (offv[b][r])
         );
      end
   end

   win_regs_t cur;
   assign cur = live[vp_in][sel_r];

   always_comb begin
      reg_rdata = 32'h0;
      if (reg_addr == OFF_VIEW) begin
         reg_rdata = {vp_in, 27'h0, vp_idx};
      end else if (sel_ok) begin
         case (fld)
            FLD_TYPE:   reg_rdata = cur.typ;
            FLD_CTRL:   reg_rdata = cur.ctrl;
            FLD_BASE_L: reg_rdata = cur.base[31:0];
            FLD_BASE_H: reg_rdata = cur.base[63:32];
            FLD_LIMIT:  reg_rdata = cur.limit;
            FLD_TGT_L:  reg_rdata = cur.target[31:0];
            FLD_TGT_H:  reg_rdata = cur.target[63:32];
            default:    reg_rdata = 32'h0;
         endcase
      end
   end

   logic             pk_found;
   logic [IDX_W-1:0] pk_idx;

   xlat_pick #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_pick (
      .req   (hv[lk_inbound]),
      .found (pk_found),
      .idx   (pk_idx)
   );

   always_comb begin
      lk_hit      = pk_found;
      lk_region   = pk_idx;
      lk_cfg      = 1'b0;
      lk_addr_out = lk_addr;
      lk_bus      = 8'h0;
      lk_devfn    = 8'h0;
      lk_cfg_off  = '0;
      if (pk_found) begin
         if (cfgv[lk_inbound][pk_idx]) begin
            lk_cfg     = 1'b1;
            lk_bus     = busv[lk_inbound][pk_idx];
            lk_devfn   = dfv[lk_inbound][pk_idx];
            lk_cfg_off = offv[lk_inbound][pk_idx];
         end else begin
            lk_addr_out = xav[lk_inbound][pk_idx];
         end
      end
   end

endmodule

// File: rtl/xlat_chk.sv
module xlat_chk #(
   parameter int NUM_REGIONS = 16,
   parameter int CFG_W       = 12,
   parameter int IDX_W       = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [11:0]       reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              lk_inbound,
   input logic [63:0]       lk_addr,
   input logic              lk_hit,
   input logic              lk_cfg,
   input logic [IDX_W-1:0]  lk_region,
   input logic [63:0]       lk_addr_out,
   input logic [7:0]        lk_bus,
   input logic [7:0]        lk_devfn,
   input logic [CFG_W-1:0]  lk_cfg_off
);

   // R10
   miss_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_hit |-> (lk_addr_out == lk_addr) && !lk_cfg &&
                  (lk_bus == 8'h0) && (lk_devfn == 8'h0) && (lk_cfg_off == '0));

   // R9
   region_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_hit |-> ({{(32-IDX_W){1'b0}}, lk_region} < NUM_REGIONS));

   // R8
   cfg_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_cfg |-> lk_hit && (lk_addr_out == lk_addr));

   // R5
   commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(reg_we) && ($past(reg_addr) != 12'h908) &&
       $stable(lk_addr) && $stable(lk_inbound))
      |-> $stable(lk_hit) && $stable(lk_cfg) && $stable(lk_addr_out) &&
          $stable(lk_region));

   // R1
   view_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 12'h900) |-> (reg_rdata[30:4] == 27'h0));

endmodule

bind xlat_window_unit xlat_chk #(
   .NUM_REGIONS (NUM_REGIONS),
   .CFG_W       (CFG_W),
   .IDX_W       (IDX_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .reg_we      (reg_we),
   .reg_addr    (reg_addr),
   .reg_rdata   (reg_rdata),
   .lk_inbound  (lk_inbound),
   .lk_addr     (lk_addr),
   .lk_hit      (lk_hit),
   .lk_cfg      (lk_cfg),
   .lk_region   (lk_region),
   .lk_addr_out (lk_addr_out),
   .lk_bus      (lk_bus),
   .lk_devfn    (lk_devfn),
   .lk_cfg_off  (lk_cfg_off)
);

// File: tb/sim_xlat_window_unit.sv
module sim_xlat_window_unit;

   localparam int N     = 4;
   localparam int CW    = 12;
   localparam int IW    = 2;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_we = 1'b0;
   logic [11:0]    reg_addr = 12'h0;
   logic [31:0]    reg_wdata = 32'h0;
   logic [31:0]    reg_rdata;
   logic           lk_inbound = 1'b0;
   logic [63:0]    lk_addr = 64'h0;
   logic           lk_hit, lk_cfg;
   logic [IW-1:0]  lk_region;
   logic [63:0]    lk_addr_out;
   logic [7:0]     lk_bus, lk_devfn;
   logic [CW-1:0]  lk_cfg_off;

   int total = 0;
   int bad   = 0;

   always #5 clk = ~clk;

   xlat_window_unit #(.NUM_REGIONS(N), .CFG_W(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_inbound(lk_inbound),
      .lk_addr(lk_addr), .lk_hit(lk_hit), .lk_cfg(lk_cfg),
      .lk_region(lk_region), .lk_addr_out(lk_addr_out), .lk_bus(lk_bus),
      .lk_devfn(lk_devfn), .lk_cfg_off(lk_cfg_off)
   );

   // bench model: live registers and captured lookup state
   logic [31:0] m_typ [2][N], m_ctl [2][N], m_lim [2][N];
   logic [63:0] m_base[2][N], m_tgt [2][N];
   logic        k_en  [2][N], k_cfg [2][N];
   logic [31:0] k_lim [2][N];
   logic [63:0] k_base[2][N], k_tgt [2][N];
   logic        m_vin;
   logic [3:0]  m_vidx;

   task automatic model_reset();
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < N; r++) begin
            m_typ[b][r] = 0; m_base[b][r] = 0; m_tgt[b][r] = 0;
            m_lim[b][r] = 32'hFFFF_FFFF;
            m_ctl[b][r] = (b == 1 && r == 0) ? 32'h8000_0000 : 32'h0;
            k_en[b][r]  = (b == 1 && r == 0);
            k_cfg[b][r] = 0; k_base[b][r] = 0; k_tgt[b][r] = 0;
            k_lim[b][r] = 32'hFFFF_FFFF;
         end
      m_vin = 0; m_vidx = 0;
   endtask

   task automatic cmp(string tag, logic [63:0] got, logic [63:0] exp);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%h exp=%h", tag, got, exp);
      end
   endtask

   task automatic wr(logic [11:0] a, logic [31:0] d);
      int b, r;
      b = m_vin; r = m_vidx;
      if (a == 12'h900) begin
         m_vin = d[31]; m_vidx = d[3:0];
      end else if (r < N) begin
         case (a)
            12'h904: m_typ[b][r] = d;
            12'h90C: m_base[b][r][31:0] = d;
            12'h910: m_base[b][r][63:32] = d;
            12'h914: m_lim[b][r] = d;
            12'h918: m_tgt[b][r][31:0] = d;
            12'h91C: m_tgt[b][r][63:32] = d;
            12'h908: begin
               m_ctl[b][r] = d; k_en[b][r] = d[31];
               k_cfg[b][r] = (m_typ[b][r] != 0); k_base[b][r] = m_base[b][r];
               k_lim[b][r] = m_lim[b][r]; k_tgt[b][r] = m_tgt[b][r];
            end
            default: ;
         endcase
      end
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   function automatic logic [31:0] exp_rd(logic [11:0] a);
      int b, r;
      b = m_vin; r = m_vidx;
      if (a == 12'h900) return {m_vin, 27'h0, m_vidx};
      if (r >= N) return 32'h0;
      case (a)
         12'h904: return m_typ[b][r];
         12'h908: return m_ctl[b][r];
         12'h90C: return m_base[b][r][31:0];
         12'h910: return m_base[b][r][63:32];
         12'h914: return m_lim[b][r];
         12'h918: return m_tgt[b][r][31:0];
         12'h91C: return m_tgt[b][r][63:32];
         default: return 32'h0;
      endcase
   endfunction

   task automatic rd(string tag, logic [11:0] a);
      @(negedge clk);
      reg_addr = a;
      #1 cmp(tag, {32'h0, reg_rdata}, {32'h0, exp_rd(a)});
   endtask

   task automatic look(string tag, logic inb, logic [63:0] a);
      logic h, c;
      logic [IW-1:0] reg_i;
      logic [63:0] o;
      logic [7:0] bu, df;
      logic [CW-1:0] of;
      int b;
      b = inb; h = 0; c = 0; reg_i = 0; o = a; bu = 0; df = 0; of = 0;
      for (int r = N - 1; r >= 0; r--)
         if (k_en[b][r] && a >= k_base[b][r] && a <= {32'h0, k_lim[b][r]}) begin
            h = 1; reg_i = IW'(r);
         end
      if (h) begin
         if (k_cfg[b][reg_i]) begin
            c = 1; bu = k_tgt[b][reg_i][31:24]; df = k_tgt[b][reg_i][23:16];
            of = CW'(a - k_base[b][reg_i]);
         end else o = k_tgt[b][reg_i] + (a - k_base[b][reg_i]);
      end
      @(negedge clk);
      lk_inbound = inb; lk_addr = a;
      #1;
      cmp({tag, " hit"}, {63'h0, lk_hit}, {63'h0, h});
      cmp({tag, " addr"}, lk_addr_out, o);
      if (h) cmp({tag, " idx"}, {62'h0, lk_region}, {62'h0, reg_i});
      cmp({tag, " cfg"}, {31'h0, lk_cfg, lk_bus, lk_devfn, 4'h0, lk_cfg_off},
          {31'h0, c, bu, df, 4'h0, of});
   endtask

   task automatic rd_all(string tag);
      for (int b = 0; b < 2; b++)
         for (int r = 0; r < N; r++) begin
            wr(12'h900, {b[0], 27'h0, r[3:0]});
            for (int f = 1; f <= 7; f++) rd(tag, 12'h900 + 12'(4 * f));
         end
   endtask

   initial begin
      #2_000_000;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model_reset();
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R4, R2: reset values of every window in both banks
      rd("R4 view", 12'h900);
      rd_all("R4 reset regs");
      // R4, R6: inbound window 0 passes traffic, outbound misses
      for (int i = 0; i < 8; i++) begin
         look("R4 in0", 1'b1, 64'(i) * 64'h2000_0001);
         look("R10 out miss", 1'b0, 64'(i) * 64'h2000_0001);
      end
      look("R6 in above limit", 1'b1, 64'h1_0000_0000);

      // R1: only bits 31 and 3:0 retained
      wr(12'h900, 32'hFFFF_FFF2);
      rd("R1 view bits", 12'h900);
      // R2: unlisted offset reads 0
      rd("R2 unlisted", 12'h920);
      wr(12'h920, 32'h1234_5678);
      rd("R2 unlisted wr", 12'h920);

      // R5, R7: outbound window 2, deferred until control write
      wr(12'h900, 32'h0000_0002);
      wr(12'h90C, 32'h0000_1000);
      wr(12'h914, 32'h0000_1FFF);
      wr(12'h918, 32'h0000_0000);
      wr(12'h91C, 32'h0000_00AB);
      wr(12'h904, 32'h0);
      look("R5 before commit", 1'b0, 64'h1800);
      wr(12'h908, 32'h8000_0000);
      for (int a = 'h0FF0; a <= 'h2010; a += 'h88)
         look("R7 sweep", 1'b0, 64'(a));
      look("R6 lower edge", 1'b0, 64'h1000);
      look("R6 upper edge", 1'b0, 64'h1FFF);
      look("R6 past upper", 1'b0, 64'h2000);

      // R9: overlapping window 1 wins where both match
      wr(12'h900, 32'h0000_0001);
      wr(12'h90C, 32'h0000_1800);
      wr(12'h914, 32'h0000_2FFF);
      wr(12'h918, 32'h5000_0000);
      wr(12'h908, 32'h8000_0000);
      for (int a = 'h0F00; a <= 'h3100; a += 'h100)
         look("R9 overlap", 1'b0, 64'(a));

      // R8: window 0 configuration type, offset masked to 12 bits
      wr(12'h900, 32'h0000_0000);
      wr(12'h904, 32'h0000_0004);
      wr(12'h90C, 32'h0000_8000);
      wr(12'h914, 32'h0000_9FFF);
      wr(12'h918, 32'h1234_0000);
      wr(12'h908, 32'h8000_0000);
      for (int a = 'h7FF0; a <= 'hA010; a += 'h3F4)
         look("R8 cfg sweep", 1'b0, 64'(a));

      // R11: type change held until captured
      wr(12'h904, 32'h0);
      look("R11 pending", 1'b0, 64'h8ABC);
      wr(12'h908, 32'h8000_0000);
      look("R11 now mem", 1'b0, 64'h8ABC);
      // R5: disable through control write
      wr(12'h908, 32'h0);
      look("R5 disabled", 1'b0, 64'h8ABC);

      // R3: out-of-range window number ignored
      for (int r = N; r < 16; r++) begin
         wr(12'h900, {28'h0, r[3:0]});
         wr(12'h90C, 32'hDEAD_0000);
         wr(12'h908, 32'h8000_0000);
         rd("R3 oob base", 12'h90C);
         rd("R3 oob ctrl", 12'h908);
      end
      look("R3 lookups intact", 1'b0, 64'h1234);

      // R12: inbound bank untouched by outbound edits
      rd_all("R12 banks");
      look("R12 inbound", 1'b1, 64'h1800);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule